// File: doc/BRIEF.md
# Two-Stage Error Event Logger

This block gathers single-cycle error pulses from a set of functional units and keeps a record of them in two layers. Inside each unit, the earliest unmasked event is latched into a capture register that then locks. Every later event in that unit collects in an overflow register. This continues until software clears the capture register with a write-one-to-clear access. Each event source carries a programmable severity bit. The bit decides whether the event counts as fatal or non-fatal. Unit activity then rolls up into a global layer with a capture/overflow pair for each severity group, indexed by unit number.

Each unit has a four-bit routing field that chooses which of four level error outputs it drives. The outputs are a system-management signal, a system-control signal, a system-error signal and a machine-check signal. An output stays high while any unit routed to it holds at least one logged bit that is currently unmasked. Software uses a single-cycle register write port and a combinational read port. The address is split as follows. `reg_addr[7:4]` selects unit 0..NUM_UNITS-1, and the value 4'hF selects the global bank. `reg_addr[3:0]` selects the register. For a unit, the register index is 0 capture, 1 overflow, 2 mask, 3 severity, 4 route. For the global bank, it is 0 fatal capture, 1 fatal overflow, 2 non-fatal capture, 3 non-fatal overflow.

Top module: `errlog_top`

## Requirements
- R1: After reset, all capture and overflow registers (unit and global) read 0, every unit mask reads all ones (all events masked), severity and route read 0, and all four error outputs are low.
- R2: When a unit's capture register is zero and exactly one unmasked event pulses, the capture register takes that event's bit in the cycle after the pulse, and the overflow register is unchanged.
- R3: While a unit's capture register is non-zero, unmasked events leave it unchanged and are ORed into that unit's overflow register.
- R4: When several unmasked events of one unit pulse together into an empty capture register, the lowest-numbered event goes to the capture register and the others go to the overflow register.
- R5: An event whose mask bit is 1 is neither logged in the unit nor in the global registers. Setting a mask bit also removes that logged bit's contribution to the routed outputs.
- R6: All capture and overflow registers are write-one-to-clear: written 1 bits clear, written 0 bits keep their value. After the capture register is cleared, the next unmasked event lands in it again.
- R7: An event whose severity bit is 1 is reported to the global fatal group at bit position equal to its unit index. An event whose severity bit is 0 goes to the non-fatal group.
- R8: In each severity group, the global capture register records the reporting unit while it is empty, and the lowest unit index wins a tie. Later reports OR into the global overflow register until the global capture register is cleared.
- R9: Route bit 0 drives `err_smgmt`, bit 1 `err_sctl`, bit 2 `err_syserr` and bit 3 `err_mchk`. Each output is high exactly when a unit with that route bit set holds an unmasked logged bit, and it drops when those bits are cleared or masked.
- R10: Mask, severity and route registers read back the value last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| err_evt | input | NUM_UNITS*EVT_W | Error pulses, unit u owns bits [u*EVT_W +: EVT_W] |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | 8 | Register address (unit/bank in [7:4], index in [3:0]) |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Combinational read data for reg_addr |
| err_smgmt | output | 1 | System-management error level |
| err_sctl | output | 1 | System-control error level |
| err_syserr | output | 1 | System-error level |
| err_mchk | output | 1 | Machine-check level |

## Verification
The main capture function is driven with four patterns, and each one separates a different behaviour. A lone pulse into an empty unit shows capture. A pulse into a locked unit shows overflow accumulation. A multi-bit pulse shows the lowest-index split. A same-cycle pulse from two units of the same severity shows the global tie rule. Masked pulses are used to show that masking blocks logging. The mask is also changed on bits that are already logged, to show that routing follows the mask. Partial write-one-to-clear writes, followed by a fresh pulse, show that clearing bits individually reopens capture.

// File: rtl/errlog_pkg.sv
package errlog_pkg;

    localparam int ADDR_W = 8;
    localparam int NSIG   = 4;

    // Route bit positions (one per error output)
    localparam int SIG_SMGMT  = 0;
    localparam int SIG_SCTL   = 1;
    localparam int SIG_SYSERR = 2;
    localparam int SIG_MCHK   = 3;

    localparam logic [3:0] BANK_GLOBAL = 4'hF;

    typedef enum logic [3:0] {
        UREG_CAPT  = 4'd0,
        UREG_OVFL  = 4'd1,
        UREG_MASK  = 4'd2,
        UREG_SEV   = 4'd3,
        UREG_ROUTE = 4'd4
    } ureg_e;

    typedef enum logic [3:0] {
        GREG_FAT_CAPT = 4'd0,
        GREG_FAT_OVFL = 4'd1,
        GREG_NF_CAPT  = 4'd2,
        GREG_NF_OVFL  = 4'd3
    } greg_e;

    typedef struct packed {
        logic [3:0] bank;
        logic [3:0] idx;
    } raddr_t;

endpackage

// File: rtl/errlog_capture.sv
module errlog_capture #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] ev,
    input  logic [W-1:0] clr_capt,
    input  logic [W-1:0] clr_ovfl,
    output logic [W-1:0] capt,
    output logic [W-1:0] ovfl
);

    logic [W-1:0] capt_kept, ovfl_kept, pick, capt_d, ovfl_d;

    always_comb begin
        capt_kept = capt & ~clr_capt;
        ovfl_kept = ovfl & ~clr_ovfl;
        pick = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (ev[i]) begin
                pick    = '0;
                pick[i] = 1'b1;
            end
        end
        if (capt_kept == '0) begin
            capt_d = pick;
            ovfl_d = ovfl_kept | (ev & ~pick);
        end else begin
            capt_d = capt_kept;
            ovfl_d = ovfl_kept | ev;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            capt <= '0;
            ovfl <= '0;
        end else begin
            capt <= capt_d;
            ovfl <= ovfl_d;
        end
    end

endmodule

// File: rtl/errlog_unit.sv
module errlog_unit
    import errlog_pkg::*;
#(
    parameter int EVT_W  = 4,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [EVT_W-1:0]  evt,
    input  logic              wr_en,
    input  ureg_e             wr_sel,
    input  logic [DATA_W-1:0] wdata,
    output logic [EVT_W-1:0]  capt,
    output logic [EVT_W-1:0]  ovfl,
    output logic [EVT_W-1:0]  mask,
    output logic [EVT_W-1:0]  sev,
    output logic [NSIG-1:0]   route,
    output logic              fat_hit,
    output logic              nf_hit,
    output logic              active
);

    logic [EVT_W-1:0] ev_live, clr_c, clr_o;

    assign ev_live = evt & ~mask;
    assign clr_c   = (wr_en && wr_sel == UREG_CAPT) ? wdata[EVT_W-1:0] : '0;
    assign clr_o   = (wr_en && wr_sel == UREG_OVFL) ? wdata[EVT_W-1:0] : '0;
    assign fat_hit = |(ev_live & sev);
    assign nf_hit  = |(ev_live & ~sev);
    assign active  = |((capt | ovfl) & ~mask);

    errlog_capture #(.W(EVT_W)) u_cap (
        .clk      (clk),
        .rst      (rst),
        .ev       (ev_live),
        .clr_capt (clr_c),
        .clr_ovfl (clr_o),
        .capt     (capt),
        .ovfl     (ovfl)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mask  <= '1;
            sev   <= '0;
            route <= '0;
        end else if (wr_en) begin
            case (wr_sel)
                UREG_MASK:  mask  <= wdata[EVT_W-1:0];
                UREG_SEV:   sev   <= wdata[EVT_W-1:0];
                UREG_ROUTE: route <= wdata[NSIG-1:0];
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/errlog_top.sv
module errlog_top
    import errlog_pkg::*;
#(
    parameter int NUM_UNITS = 3,
    parameter int EVT_W     = 4,
    parameter int DATA_W    = 16
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [NUM_UNITS*EVT_W-1:0] err_evt,
    input  logic                       reg_we,
    input  logic [ADDR_W-1:0]          reg_addr,
    input  logic [DATA_W-1:0]          reg_wdata,
    output logic [DATA_W-1:0]          reg_rdata,
    output logic                       err_smgmt,
    output logic                       err_sctl,
    output logic                       err_syserr,
    output logic                       err_mchk
);

    localparam int UIDX_W = 4;

    raddr_t ra;
    assign ra = raddr_t'(reg_addr);

    logic [NUM_UNITS-1:0][EVT_W-1:0] u_capt, u_ovfl, u_mask, u_sev;
    logic [NUM_UNITS-1:0][NSIG-1:0]  u_route;
    logic [NUM_UNITS-1:0]            u_fat, u_nf, u_act;
    logic [NUM_UNITS-1:0]            g_fat_capt, g_fat_ovfl, g_nf_capt, g_nf_ovfl;
    logic [NSIG-1:0]                 sig_vec;

    for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
        logic sel;
        assign sel = reg_we && (ra.bank == UIDX_W'(u));
        errlog_unit #(.EVT_W(EVT_W), .DATA_W(DATA_W)) u_unit (
            .clk     (clk),
            .rst     (rst),
            .evt     (err_evt[u*EVT_W +: EVT_W]),
            .wr_en   (sel),
            .wr_sel  (ureg_e'(ra.idx)),
            .wdata   (reg_wdata),
            .capt    (u_capt[u]),
            .ovfl    (u_ovfl[u]),
            .mask    (u_mask[u]),
            .sev     (u_sev[u]),
            .route   (u_route[u]),
            .fat_hit (u_fat[u]),
            .nf_hit  (u_nf[u]),
            .active  (u_act[u])
        );
    end

    logic gsel;
    assign gsel = reg_we && (ra.bank == BANK_GLOBAL);

    errlog_capture #(.W(NUM_UNITS)) u_gfat (
        .clk      (clk),
        .rst      (rst),
        .ev       (u_fat),
        .clr_capt ((gsel && ra.idx == GREG_FAT_CAPT) ? reg_wdata[NUM_UNITS-1:0] : '0),
        .clr_ovfl ((gsel && ra.idx == GREG_FAT_OVFL) ? reg_wdata[NUM_UNITS-1:0] : '0),
        .capt     (g_fat_capt),
        .ovfl     (g_fat_ovfl)
    );

    errlog_capture #(.W(NUM_UNITS)) u_gnf (
        .clk      (clk),
        .rst      (rst),
        .ev       (u_nf),
        .clr_capt ((gsel && ra.idx == GREG_NF_CAPT) ? reg_wdata[NUM_UNITS-1:0] : '0),
        .clr_ovfl ((gsel && ra.idx == GREG_NF_OVFL) ? reg_wdata[NUM_UNITS-1:0] : '0),
        .capt     (g_nf_capt),
        .ovfl     (g_nf_ovfl)
    );

    always_comb begin
        sig_vec = '0;
        for (int u = 0; u < NUM_UNITS; u++) begin
            sig_vec = sig_vec | (u_route[u] & {NSIG{u_act[u]}});
        end
    end

    assign err_smgmt  = sig_vec[SIG_SMGMT];
    assign err_sctl   = sig_vec[SIG_SCTL];
    assign err_syserr = sig_vec[SIG_SYSERR];
    assign err_mchk   = sig_vec[SIG_MCHK];

    always_comb begin
        reg_rdata = '0;
        if (ra.bank == BANK_GLOBAL) begin
            case (ra.idx)
                GREG_FAT_CAPT: reg_rdata = DATA_W'(g_fat_capt);
                GREG_FAT_OVFL: reg_rdata = DATA_W'(g_fat_ovfl);
                GREG_NF_CAPT:  reg_rdata = DATA_W'(g_nf_capt);
                GREG_NF_OVFL:  reg_rdata = DATA_W'(g_nf_ovfl);
                default:       reg_rdata = '0;
            endcase
        end else begin
            for (int u = 0; u < NUM_UNITS; u++) begin
                if (ra.bank == UIDX_W'(u)) begin
                    case (ra.idx)
                        UREG_CAPT:  reg_rdata = DATA_W'(u_capt[u]);
                        UREG_OVFL:  reg_rdata = DATA_W'(u_ovfl[u]);
                        UREG_MASK:  reg_rdata = DATA_W'(u_mask[u]);
                        UREG_SEV:   reg_rdata = DATA_W'(u_sev[u]);
                        UREG_ROUTE: reg_rdata = DATA_W'(u_route[u]);
                        default:    reg_rdata = '0;
                    endcase
                end
            end
        end
    end

endmodule

// File: rtl/errlog_chk.sv
module errlog_chk #(
    parameter int NUM_UNITS = 3,
    parameter int EVT_W     = 4
) (
    input logic                            clk,
    input logic                            rst,
    input logic                            reg_we,
    input logic [7:0]                      reg_addr,
    input logic [NUM_UNITS-1:0][EVT_W-1:0] u_capt,
    input logic [NUM_UNITS-1:0][EVT_W-1:0] u_ovfl,
    input logic [NUM_UNITS-1:0][EVT_W-1:0] u_mask,
    input logic [NUM_UNITS-1:0]            g_fat_capt,
    input logic [NUM_UNITS-1:0]            g_nf_capt,
    input logic                            err_smgmt,
    input logic                            err_sctl,
    input logic                            err_syserr,
    input logic                            err_mchk
);

    for (genvar u = 0; u < NUM_UNITS; u++) begin : g_u
        localparam logic [7:0] CAPT_A = 8'(u * 16);
        localparam logic [7:0] OVFL_A = 8'(u * 16 + 1);

        // R1: masks come out of reset all set
        p_reset_mask_r1: assert property (@(posedge clk)
            rst |=> (u_mask[u] == '1));

        // R2: capture register never holds more than one bit
        p_capt_single_r2: assert property (@(posedge clk) disable iff (rst)
            $onehot0(u_capt[u]));

        // R3: a locked capture register is stable unless software clears it
        p_capt_lock_r3: assert property (@(posedge clk) disable iff (rst)
            (u_capt[u] != '0 && !(reg_we && reg_addr == CAPT_A)) |=> $stable(u_capt[u]));

        // R3: overflow only gains bits unless software clears it
        p_ovfl_grow_r3: assert property (@(posedge clk) disable iff (rst)
            !(reg_we && reg_addr == OVFL_A) |=> ((u_ovfl[u] & $past(u_ovfl[u])) == $past(u_ovfl[u])));
    end

    // R8: a single winner in each global capture register
    p_gcapt_single_r8: assert property (@(posedge clk) disable iff (rst)
        $onehot0(g_fat_capt) && $onehot0(g_nf_capt));

    // R9: no output without any logged bit
    p_quiet_outputs_r9: assert property (@(posedge clk) disable iff (rst)
        (u_capt == '0 && u_ovfl == '0) |-> !(err_smgmt || err_sctl || err_syserr || err_mchk));

endmodule

bind errlog_top errlog_chk #(.NUM_UNITS(NUM_UNITS), .EVT_W(EVT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .reg_we     (reg_we),
    .reg_addr   (reg_addr),
    .u_capt     (u_capt),
    .u_ovfl     (u_ovfl),
    .u_mask     (u_mask),
    .g_fat_capt (g_fat_capt),
    .g_nf_capt  (g_nf_capt),
    .err_smgmt  (err_smgmt),
    .err_sctl   (err_sctl),
    .err_syserr (err_syserr),
    .err_mchk   (err_mchk)
);

// File: tb/sim_errlog_top.sv
`timescale 1ns/1ps
module sim_errlog_top;

    localparam int NU = 3;
    localparam int EW = 4;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NU*EW-1:0] err_evt = '0;
    logic          reg_we = 1'b0;
    logic [7:0]    reg_addr = '0;
    logic [DW-1:0] reg_wdata = '0;
    logic [DW-1:0] reg_rdata;
    logic          err_smgmt, err_sctl, err_syserr, err_mchk;

    always #2.5 clk = ~clk;

    errlog_top #(.NUM_UNITS(NU), .EVT_W(EW), .DATA_W(DW)) u0 (
        .clk        (clk),
        .rst        (rst),
        .err_evt    (err_evt),
        .reg_we     (reg_we),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .err_smgmt  (err_smgmt),
        .err_sctl   (err_sctl),
        .err_syserr (err_syserr),
        .err_mchk   (err_mchk)
    );

    typedef struct {
        bit          is_sig;
        logic [7:0]  addr;
        logic [DW-1:0] exp;
        string       req;
    } item_t;

    item_t q[$];
    int checks = 0;
    int errors = 0;
    bit done = 0;

    // monitor: pops expected items and compares away from the clock edge
    always @(negedge clk) begin
        #1;
        while (q.size() > 0) begin
            item_t it;
            logic [DW-1:0] act;
            it = q.pop_front();
            if (it.is_sig) act = DW'({err_mchk, err_syserr, err_sctl, err_smgmt});
            else           act = reg_rdata;
            checks++;
            if (act !== it.exp) begin
                errors++;
                $display("FAIL %s addr=%h actual=%h expected=%h", it.req, it.addr, act, it.exp);
            end
        end
    end

    task automatic chk(input logic [7:0] a, input logic [DW-1:0] e, input string r);
        @(negedge clk);
        reg_addr = a;
        q.push_back('{0, a, e, r});
    endtask

    task automatic chk_sig(input logic [3:0] e, input string r);
        @(negedge clk);
        q.push_back('{1, 8'h00, DW'(e), r});
    endtask

    task automatic wr(input logic [7:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic pulse(input logic [NU*EW-1:0] v);
        @(negedge clk);
        err_evt = v;
        @(negedge clk);
        err_evt = '0;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk(8'h02, 16'h000F, "R1 mask u0");
        chk(8'h22, 16'h000F, "R1 mask u2");
        chk(8'h10, 16'h0000, "R1 capt u1");
        chk(8'hF0, 16'h0000, "R1 gfat capt");
        chk(8'h14, 16'h0000, "R1 route u1");
        chk_sig(4'b0000, "R1 outputs");

        // R5 masked at reset: pulse is dropped
        pulse(12'hFFF);
        chk(8'h00, 16'h0000, "R5 masked capt u0");
        chk(8'hF2, 16'h0000, "R5 masked gnf capt");

        // configuration
        wr(8'h02, 16'h0); wr(8'h12, 16'h0); wr(8'h22, 16'h0);
        wr(8'h04, 16'h1); wr(8'h14, 16'h4); wr(8'h24, 16'h8);
        wr(8'h13, 16'hF); wr(8'h23, 16'h2);
        chk(8'h14, 16'h0004, "R10 route u1");
        chk(8'h23, 16'h0002, "R10 sev u2");
        chk(8'h12, 16'h0000, "R10 mask u1");

        // R2 single event into empty unit
        pulse(12'h004);
        chk(8'h00, 16'h0004, "R2 capt u0");
        chk(8'h01, 16'h0000, "R2 ovfl u0");
        chk(8'hF2, 16'h0001, "R7 gnf capt");
        chk(8'hF0, 16'h0000, "R7 gfat capt");
        chk_sig(4'b0001, "R9 smgmt");

        // R3 locked capture
        pulse(12'h003);
        chk(8'h00, 16'h0004, "R3 capt u0");
        chk(8'h01, 16'h0003, "R3 ovfl u0");
        chk(8'hF3, 16'h0001, "R8 gnf ovfl");

        // R4 multi-bit split
        pulse(12'h0A0);
        chk(8'h10, 16'h0002, "R4 capt u1");
        chk(8'h11, 16'h0008, "R4 ovfl u1");
        chk(8'hF0, 16'h0002, "R7 gfat capt");
        chk_sig(4'b0101, "R9 syserr");

        pulse(12'h100);
        chk(8'h20, 16'h0001, "R2 capt u2");
        chk(8'hF3, 16'h0005, "R8 gnf ovfl");
        chk_sig(4'b1101, "R9 mchk");

        // R6 clear global nf, R8 tie
        wr(8'hF2, 16'h1); wr(8'hF3, 16'h5);
        chk(8'hF2, 16'h0000, "R6 gnf capt clr");
        chk(8'hF3, 16'h0000, "R6 gnf ovfl clr");
        pulse(12'h808);
        chk(8'hF2, 16'h0001, "R8 tie capt");
        chk(8'hF3, 16'h0004, "R8 tie ovfl");
        chk(8'h01, 16'h000B, "R3 ovfl u0");
        chk(8'h21, 16'h0008, "R3 ovfl u2");

        // R5/R9 mask on logged bits
        wr(8'h12, 16'h2);
        chk_sig(4'b1101, "R9 partial mask");
        wr(8'h12, 16'hA);
        chk_sig(4'b1001, "R5 mask drops syserr");

        // R6 clear unit 1, then masked pulse
        wr(8'h10, 16'h2); wr(8'h11, 16'h8);
        chk(8'h10, 16'h0000, "R6 capt u1");
        chk(8'h11, 16'h0000, "R6 ovfl u1");
        pulse(12'h0A0);
        chk(8'h10, 16'h0000, "R5 capt u1");
        chk(8'h11, 16'h0000, "R5 ovfl u1");
        chk(8'hF1, 16'h0000, "R5 gfat ovfl");

        // R6 partial clear and reopen
        wr(8'h00, 16'h4);
        chk(8'h00, 16'h0000, "R6 capt u0");
        chk(8'h01, 16'h000B, "R6 ovfl kept");
        wr(8'h01, 16'h1);
        chk(8'h01, 16'h000A, "R6 partial clr");
        pulse(12'h002);
        chk(8'h00, 16'h0002, "R6 reopen capt");
        chk(8'h01, 16'h000A, "R6 ovfl same");

        // R8 global overflow in fatal group
        wr(8'h12, 16'h0);
        pulse(12'h010);
        chk(8'h10, 16'h0001, "R2 capt u1");
        chk(8'hF0, 16'h0002, "R8 gfat capt held");
        chk(8'hF1, 16'h0002, "R8 gfat ovfl");
        chk_sig(4'b1101, "R9 all");

        // R9 drop after clear
        wr(8'h20, 16'h1); wr(8'h21, 16'h8);
        chk_sig(4'b0101, "R9 mchk drops");

        @(negedge clk);
        #2;
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule